// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds wall-clock time and date in packed BCD: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century flag. A base-rate enable (`tick_i`) feeds an internal prescaler that produces one advance every `TICKS_PER_SEC` ticks. Each advance steps the seconds, and carries ripple upward through minutes, hours, days, months, years and the century flag. A mode input selects 24-hour counting or 12-hour counting with a PM flag stored in the hour field.

Software loads any field through a single write port. A field select picks the target and an 8-bit data word carries the value. Loading the seconds field also restarts the prescaler phase, so the next advance comes one full second after the write. Four single-cycle strobes mark the second, minute, hour and month boundaries for the interrupt logic that sits beside this block.

Month length follows the calendar. February gets 29 days when the two-digit year is a multiple of four, and 28 days otherwise.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00, weekday 0, day 01, month 01, year 00 and century 0, with all strobes low.
- R2: The seconds field advances in BCD once per `TICKS_PER_SEC` asserted `tick_i` cycles. It wraps 59 to 00, and `sec_stb_o` pulses in the cycle the new value appears.
- R3: When seconds wrap, minutes advance in BCD and `min_stb_o` pulses. Minutes wrap 59 to 00.
- R4: In 24-hour mode (`mode24_i`=1) the minute wrap advances the hour 00..23 and pulses `hour_stb_o`. The step 23 to 00 carries into the date.
- R5: In 12-hour mode (`mode24_i`=0), `hour_o` bit 6 is the PM flag and bits 5:0 hold BCD 12,01..11. Hour 11 steps to 12 and inverts the flag. Hour 12 steps to 01. Only the step from 11 PM to 12 AM carries into the date.
- R6: The weekday counts 0..6, wraps to 0, and advances on each date carry.
- R7: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. The month wrap also advances the month.
- R8: February wraps after day 29 when the BCD year is a multiple of four (year 00 included), and after day 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and inverts `century_o`.
- R10: `month_stb_o` pulses when the date wraps to day 01. This happens together with the hour strobe, with the time reading 00:00:00.
- R11: Writing seconds clears the prescaler, so the next advance takes `TICKS_PER_SEC` further ticks. A seconds write in the same cycle as a completing tick wins, and that second is not counted.
- R12: Write select codes are: 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year. For the month code, data bit 7 loads the century flag and bits 4:0 load the month. Code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base-rate enable into the prescaler |
| mode24_i | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select code |
| wr_data_i | input | 8 | Field write data |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 7 | Hour, BCD in bits 5:0, PM flag in bit 6 |
| wday_o | output | 3 | Day of week 0..6 |
| mday_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD |
| century_o | output | 1 | Century flag |
| year_o | output | 8 | Two-digit year, BCD |
| sec_stb_o | output | 1 | Pulse on every second advance |
| min_stb_o | output | 1 | Pulse on the minute boundary |
| hour_stb_o | output | 1 | Pulse on the hour boundary |
| month_stb_o | output | 1 | Pulse on the first day of a month |

## Verification
A wrong day-length decision or leap test only shows at a month end, and then it appears within one second: the date reads 31 or 29 where 01 was due. A misplaced PM flip shows at the next 11 o'clock step. A dropped carry shows as a missing or stray strobe on the same cycle as the boundary. The bench therefore loads each state one second before a boundary and compares every field and the month strobe right after that second. It also counts prescaler ticks exactly around seconds writes.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_WDAY = 3'd3,
      FLD_MDAY = 3'd4,
      FLD_MON  = 3'd5,
      FLD_YEAR = 3'd6
   } field_e;

   localparam int SEC_W  = 7;
   localparam int HOUR_W = 7;
   localparam int WDAY_W = 3;
   localparam int MDAY_W = 6;
   localparam int MON_W  = 5;
   localparam int YEAR_W = 8;

   // two-digit BCD increment (no wrap handling)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return v + 8'd1;
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      logic [7:0] bin;
      bin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
      return (bin[1:0] == 2'b00);
   endfunction

   function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic adv_o
);
   localparam int          CW   = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
   localparam bit          POW2 = ((TICKS & (TICKS - 1)) == 0);

   logic [CW-1:0] cnt_q;

   if (TICKS < 2) begin : g_bad_ticks
      $error("rtc_prescaler: TICKS must be at least 2");
   end

   assign adv_o = tick_i && !clr_i && (cnt_q == LAST);

   if (POW2) begin : g_pow2
      // counter wraps naturally at a power of two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (tick_i) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_modn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
   import rtc_cal_pkg::*;
#(
   parameter int W    = 7,
   parameter int MINV = 'h00,
   parameter int MAXV = 'h59,
   parameter int RSTV = 'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] val_o,
   output logic         wrap_o
);
   if (W < 1 || W > 8) begin : g_bad_w
      $error("rtc_bcd_wrap: W must be 1..8");
   end

   assign wrap_o = adv_i && (val_o == W'(MAXV));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_o <= W'(RSTV);
      else if (wr_i)   val_o <= wdata_i;
      else if (wrap_o) val_o <= W'(MINV);
      else if (adv_i)  val_o <= W'(bcd_inc(8'(val_o)));
   end

endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
   import rtc_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode24_i,
   input  logic              adv_i,
   input  logic              wr_i,
   input  logic [HOUR_W-1:0] wdata_i,
   output logic [HOUR_W-1:0] hour_o,
   output logic              day_o
);
   logic [5:0]        h;
   logic              pm;
   logic [HOUR_W-1:0] nxt;

   assign h  = hour_o[5:0];
   assign pm = hour_o[6];

   always_comb begin
      day_o = 1'b0;
      nxt   = hour_o;
      if (mode24_i) begin
         if (h == 6'h23) begin
            nxt   = '0;
            day_o = adv_i;
         end else begin
            nxt = {1'b0, 6'(bcd_inc(8'(h)))};
         end
      end else begin
         if (h == 6'h11) begin
            nxt   = {~pm, 6'h12};
            day_o = adv_i && pm;
         end else if (h == 6'h12) begin
            nxt = {pm, 6'h01};
         end else begin
            nxt = {pm, 6'(bcd_inc(8'(h)))};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hour_o <= '0;
      else if (wr_i)  hour_o <= wdata_i;
      else if (adv_i) hour_o <= nxt;
   end

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
   import rtc_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              day_i,
   input  logic              wr_wday_i,
   input  logic              wr_mday_i,
   input  logic              wr_mon_i,
   input  logic              wr_year_i,
   input  logic [7:0]        wdata_i,
   output logic [WDAY_W-1:0] wday_o,
   output logic [MDAY_W-1:0] mday_o,
   output logic [MON_W-1:0]  mon_o,
   output logic              century_o,
   output logic [YEAR_W-1:0] year_o,
   output logic              month_o
);
   logic last_day, year_step, cent_flip;

   assign last_day  = (mday_o == month_len(mon_o, year_o));
   assign month_o   = day_i && last_day;
   assign year_step = month_o && (mon_o == 5'h12);
   assign cent_flip = year_step && (year_o == 8'h99);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wday_o    <= '0;
         mday_o    <= 6'h01;
         mon_o     <= 5'h01;
         year_o    <= 8'h00;
         century_o <= 1'b0;
      end else begin
         if (wr_wday_i)  wday_o <= wdata_i[2:0];
         else if (day_i) wday_o <= (wday_o == 3'd6) ? 3'd0 : wday_o + 3'd1;

         if (wr_mday_i)  mday_o <= wdata_i[5:0];
         else if (day_i) mday_o <= last_day ? 6'h01 : 6'(bcd_inc(8'(mday_o)));

         if (wr_mon_i) begin
            mon_o     <= wdata_i[4:0];
            century_o <= wdata_i[7];
         end else begin
            if (month_o)   mon_o     <= (mon_o == 5'h12) ? 5'h01 : 5'(bcd_inc(8'(mon_o)));
            if (cent_flip) century_o <= ~century_o;
         end

         if (wr_year_i)      year_o <= wdata_i;
         else if (year_step) year_o <= (year_o == 8'h99) ? 8'h00 : bcd_inc(year_o);
      end
   end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              mode24_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_sel_i,
   input  logic [7:0]        wr_data_i,
   output logic [SEC_W-1:0]  sec_o,
   output logic [SEC_W-1:0]  min_o,
   output logic [HOUR_W-1:0] hour_o,
   output logic [WDAY_W-1:0] wday_o,
   output logic [MDAY_W-1:0] mday_o,
   output logic [MON_W-1:0]  mon_o,
   output logic              century_o,
   output logic [YEAR_W-1:0] year_o,
   output logic              sec_stb_o,
   output logic              min_stb_o,
   output logic              hour_stb_o,
   output logic              month_stb_o
);
   localparam int NMS = 2;   // seconds and minutes share one counter shape

   logic             sec_adv, day_carry, month_wrap;
   logic [NMS:0]     chain;
   logic [NMS-1:0]   ms_wr;
   logic [SEC_W-1:0] ms_val [NMS];

   function automatic logic sel_is(input field_e f);
      return wr_en_i && (wr_sel_i == f);
   endfunction

   assign ms_wr[0] = sel_is(FLD_SEC);
   assign ms_wr[1] = sel_is(FLD_MIN);

   rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .clr_i  (ms_wr[0]),
      .adv_o  (sec_adv)
   );

   assign chain[0] = sec_adv;

   for (genvar g = 0; g < NMS; g++) begin : g_ms
      rtc_bcd_wrap #(.W(SEC_W), .MINV('h00), .MAXV('h59), .RSTV('h00)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv_i   (chain[g]),
         .wr_i    (ms_wr[g]),
         .wdata_i (wr_data_i[SEC_W-1:0]),
         .val_o   (ms_val[g]),
         .wrap_o  (chain[g+1])
      );
   end

   assign sec_o = ms_val[0];
   assign min_o = ms_val[1];

   rtc_hour_cnt u_hour (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode24_i (mode24_i),
      .adv_i    (chain[NMS]),
      .wr_i     (sel_is(FLD_HOUR)),
      .wdata_i  (wr_data_i[HOUR_W-1:0]),
      .hour_o   (hour_o),
      .day_o    (day_carry)
   );

   rtc_date_cnt u_date (
      .clk       (clk),
      .rst_n     (rst_n),
      .day_i     (day_carry),
      .wr_wday_i (sel_is(FLD_WDAY)),
      .wr_mday_i (sel_is(FLD_MDAY)),
      .wr_mon_i  (sel_is(FLD_MON)),
      .wr_year_i (sel_is(FLD_YEAR)),
      .wdata_i   (wr_data_i),
      .wday_o    (wday_o),
      .mday_o    (mday_o),
      .mon_o     (mon_o),
      .century_o (century_o),
      .year_o    (year_o),
      .month_o   (month_wrap)
   );

   // strobes land on the same edge as the counter values they announce
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_stb_o   <= 1'b0;
         min_stb_o   <= 1'b0;
         hour_stb_o  <= 1'b0;
         month_stb_o <= 1'b0;
      end else begin
         sec_stb_o   <= chain[0];
         min_stb_o   <= chain[1];
         hour_stb_o  <= chain[2];
         month_stb_o <= month_wrap;
      end
   end

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       wr_en_i,
   input logic [2:0] wr_sel_i,
   input logic [6:0] sec_o,
   input logic [5:0] mday_o,
   input logic       sec_stb_o,
   input logic       min_stb_o,
   input logic       hour_stb_o,
   input logic       month_stb_o
);
   p_secstb_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_stb_o |-> $past(tick_i));

   p_minstb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      min_stb_o |-> (sec_stb_o && sec_o == 7'h00));

   p_hourstb_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hour_stb_o |-> min_stb_o);

   p_monthstb_day1_r10: assert property (@(posedge clk) disable iff (!rst_n)
      month_stb_o |-> (hour_stb_o && mday_o == 6'h01));

   p_sec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_stb_o && !$past(wr_en_i && wr_sel_i == 3'd0)) |-> $stable(sec_o));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .sec_o       (sec_o),
   .mday_o      (mday_o),
   .sec_stb_o   (sec_stb_o),
   .min_stb_o   (min_stb_o),
   .hour_stb_o  (hour_stb_o),
   .month_stb_o (month_stb_o)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
   localparam int TPS = 4;
   localparam int NV  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       mode24_i = 1'b1;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_sel_i = 3'd0;
   logic [7:0] wr_data_i = 8'd0;
   logic [6:0] sec_o, min_o, hour_o;
   logic [2:0] wday_o;
   logic [5:0] mday_o;
   logic [4:0] mon_o;
   logic       century_o;
   logic [7:0] year_o;
   logic       sec_stb_o, min_stb_o, hour_stb_o, month_stb_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_calendar_core #(.TICKS_PER_SEC(TPS)) u_dut (
      .clk, .rst_n, .tick_i, .mode24_i, .wr_en_i, .wr_sel_i, .wr_data_i,
      .sec_o, .min_o, .hour_o, .wday_o, .mday_o, .mon_o, .century_o, .year_o,
      .sec_stb_o, .min_stb_o, .hour_stb_o, .month_stb_o
   );

   // {mode24, hour, wday, mday, monbyte, year, e_hour, e_wday, e_mday, e_monbyte, e_year, e_mstb}
   // each state is loaded at hh:59:59 and advanced by one second
   localparam logic [81:0] VEC [NV] = '{
      {1'b1, 8'h23, 8'h06, 8'h31, 8'h01, 8'h24,  8'h00, 8'h00, 8'h01, 8'h02, 8'h24, 1'b1}, // R4 R6 R10
      {1'b1, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24,  8'h00, 8'h03, 8'h01, 8'h05, 8'h24, 1'b1}, // R7
      {1'b1, 8'h23, 8'h02, 8'h30, 8'h05, 8'h24,  8'h00, 8'h03, 8'h31, 8'h05, 8'h24, 1'b0}, // R7
      {1'b1, 8'h23, 8'h00, 8'h28, 8'h02, 8'h24,  8'h00, 8'h01, 8'h29, 8'h02, 8'h24, 1'b0}, // R8
      {1'b1, 8'h23, 8'h00, 8'h29, 8'h02, 8'h24,  8'h00, 8'h01, 8'h01, 8'h03, 8'h24, 1'b1}, // R8
      {1'b1, 8'h23, 8'h00, 8'h28, 8'h02, 8'h23,  8'h00, 8'h01, 8'h01, 8'h03, 8'h23, 1'b1}, // R8
      {1'b1, 8'h23, 8'h00, 8'h28, 8'h02, 8'h00,  8'h00, 8'h01, 8'h29, 8'h02, 8'h00, 1'b0}, // R8
      {1'b1, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99,  8'h00, 8'h04, 8'h01, 8'h81, 8'h00, 1'b1}, // R9
      {1'b1, 8'h23, 8'h03, 8'h31, 8'h92, 8'h99,  8'h00, 8'h04, 8'h01, 8'h01, 8'h00, 1'b1}, // R9
      {1'b1, 8'h23, 8'h03, 8'h31, 8'h12, 8'h41,  8'h00, 8'h04, 8'h01, 8'h01, 8'h42, 1'b1}, // R9
      {1'b1, 8'h23, 8'h04, 8'h30, 8'h09, 8'h24,  8'h00, 8'h05, 8'h01, 8'h10, 8'h24, 1'b1}, // R7
      {1'b1, 8'h23, 8'h04, 8'h30, 8'h11, 8'h24,  8'h00, 8'h05, 8'h01, 8'h12, 8'h24, 1'b1}, // R7
      {1'b1, 8'h22, 8'h04, 8'h15, 8'h06, 8'h24,  8'h23, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R4
      {1'b1, 8'h19, 8'h04, 8'h15, 8'h06, 8'h24,  8'h20, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R4
      {1'b0, 8'h11, 8'h04, 8'h15, 8'h06, 8'h24,  8'h52, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R5
      {1'b0, 8'h51, 8'h04, 8'h15, 8'h06, 8'h24,  8'h12, 8'h05, 8'h16, 8'h06, 8'h24, 1'b0}, // R5
      {1'b0, 8'h12, 8'h04, 8'h15, 8'h06, 8'h24,  8'h01, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R5
      {1'b0, 8'h52, 8'h04, 8'h15, 8'h06, 8'h24,  8'h41, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R5
      {1'b0, 8'h09, 8'h04, 8'h15, 8'h06, 8'h24,  8'h10, 8'h04, 8'h15, 8'h06, 8'h24, 1'b0}, // R5
      {1'b1, 8'h23, 8'h06, 8'h30, 8'h06, 8'h24,  8'h00, 8'h00, 8'h01, 8'h07, 8'h24, 1'b1}  // R6
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
      end
      tick_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [81:0] v;
      logic [63:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 reset fields",
          64'({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, century_o, year_o}),
          64'({7'h00, 7'h00, 7'h00, 3'd0, 6'h01, 5'h01, 1'b0, 8'h00}));
      chk("R1 reset strobes", 64'({sec_stb_o, min_stb_o, hour_stb_o, month_stb_o}), 64'(0));

      // R11: seconds write restarts the prescaler
      wr(3'd0, 8'h09);
      ticks(TPS - 1);
      chk("R11 no advance before full second", 64'(sec_o), 64'h09);
      ticks(1);
      chk("R2 BCD 09 to 10", 64'({sec_o, sec_stb_o}), 64'({7'h10, 1'b1}));

      ticks(2);
      wr(3'd0, 8'h20);
      ticks(TPS - 1);
      chk("R11 phase cleared mid-second", 64'(sec_o), 64'h20);
      ticks(1);
      chk("R11 advance after clear", 64'(sec_o), 64'h21);

      // R11: coincident write and completing tick, write wins
      ticks(TPS - 1);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h30;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      chk("R11 write beats tick", 64'({sec_o, sec_stb_o}), 64'({7'h30, 1'b0}));
      ticks(TPS - 1);
      chk("R11 hold after coincident write", 64'(sec_o), 64'h30);
      ticks(1);
      chk("R11 next advance", 64'(sec_o), 64'h31);

      // R2 R3: seconds wrap carries into minutes
      mode24_i = 1'b1;
      wr(3'd2, 8'h07);
      wr(3'd1, 8'h05);
      wr(3'd0, 8'h59);
      ticks(TPS);
      chk("R3 minute carry", 64'({sec_o, min_o, sec_stb_o, min_stb_o, hour_stb_o}),
          64'({7'h00, 7'h06, 1'b1, 1'b1, 1'b0}));

      // R4: minute wrap carries into hour
      wr(3'd1, 8'h59);
      wr(3'd0, 8'h59);
      ticks(TPS);
      chk("R4 hour carry", 64'({min_o, hour_o, hour_stb_o, month_stb_o}),
          64'({7'h00, 7'h08, 1'b1, 1'b0}));

      // R12: select code 7 touches nothing
      snap = 64'({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, century_o, year_o});
      wr(3'd7, 8'h33);
      chk("R12 unused code ignored",
          64'({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, century_o, year_o}), snap);
      wr(3'd6, 8'h57);
      wr(3'd5, 8'hE9);
      chk("R12 year and month byte load", 64'({year_o, century_o, mon_o}),
          64'({8'h57, 1'b1, 5'h09}));

      // table walk: one second before each boundary
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         mode24_i = v[81];
         wr(3'd2, v[80:73]);
         wr(3'd3, v[72:65]);
         wr(3'd4, v[64:57]);
         wr(3'd5, v[56:49]);
         wr(3'd6, v[48:41]);
         wr(3'd1, 8'h59);
         wr(3'd0, 8'h59);
         ticks(TPS);
         chk($sformatf("vector %0d R4/R5/R6/R7/R8/R9/R10", i),
             64'({1'b0, hour_o, 5'd0, wday_o, 2'd0, mday_o, century_o, 2'd0, mon_o, year_o, month_stb_o}),
             64'(v[40:0]));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule